// File: doc/BRIEF.md
# PWM display period sequencer

The block times the grayscale display period of a bank of constant-current LED outputs. Each channel owns a grayscale value of `GS_W` bits. A counter paced by the grayscale clock runs from 1 up to `2**GS_W`, and each channel is lit while the count has not yet passed its value. A period that runs to the end raises a single-cycle marker on its last count.

The period starts on one of two events: blank being released, or a rising edge on the grayscale latch strobe while the timing-reset enable is set. A latch strobe that arrives in the middle of a period restarts it from count 1. Blank takes priority over everything else. It darkens every channel in the same cycle, clears the counter and holds the sequencer idle. When the repeat control is set, periods follow one another with no gap. When it is clear, one period runs and the outputs then stay dark until the next start event.

Top module: `pwm_period_seq`

## Requirements
- R1: While a period runs, the count takes the values 1, 2, …, `2**GS_W` and advances by exactly one on each clock.
- R2: Channel n takes its value from `gs_data[n*GS_W +: GS_W]`. Its `ch_on[n]` is 1 exactly when a period is running, `blank` is low, the value is nonzero and the count is less than or equal to the value.
- R3: A value of 0 keeps its channel dark for the whole period. The all-ones value lights it for counts 1 to `2**GS_W - 1` and darkens it on the final count.
- R4: `period_end` is high for exactly one cycle, the cycle in which the count equals `2**GS_W`.
- R5: With `repeat_en` at 1 on the final count, the following cycle shows count 1 of a new period.
- R6: With `repeat_en` at 0 on the final count, the sequencer goes idle. All outputs and `period_end` then stay low until a start event.
- R7: While `blank` is 1, every `ch_on` bit and `period_end` are 0 in that same cycle, and the counter is held cleared. Holding `blank` high never starts a period.
- R8: A 1-to-0 transition of `blank` seen at a clock edge starts a period, which shows count 1 in the cycle after that edge.
- R9: A 0-to-1 transition of `lat_gs` with `tmg_rst_en` at 1 and `blank` low starts a period at count 1 in the next cycle, even in the middle of a running period. With `tmg_rst_en` at 0 the strobe has no effect.
- R10: After reset all outputs are 0, and they stay 0 until a start event occurs.
- R11: A latch strobe that arrives while `blank` is 1 is ignored, whatever the timing-reset setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grayscale clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blank | input | 1 | Forces outputs dark and holds the sequencer idle |
| repeat_en | input | 1 | 1: periods run back to back; 0: one period per start |
| tmg_rst_en | input | 1 | Lets a latch strobe restart the period |
| lat_gs | input | 1 | Grayscale latch strobe; its rising edge is used |
| gs_data | input | NUM_CH*GS_W | Grayscale values, channel n in bits n*GS_W +: GS_W |
| ch_on | output | NUM_CH | Per-channel PWM on/off |
| period_end | output | 1 | One-cycle marker on the final count of a period |

## Verification
A counter that skips or repeats a value moves the falling edge of every channel whose value lies beyond the fault. That shows on `ch_on` within the same period, and `period_end` lands on the wrong cycle. A wrong idle/running state after the final count appears one cycle later: a one-shot period relights, or a repeating one stays dark. A fault in the edge detectors appears one cycle after the blank release or the latch strobe, as a missing start or a spurious one.

// File: rtl/pws_pkg.sv
package pws_pkg;

    typedef enum logic {
        PWS_IDLE = 1'b0,
        PWS_RUN  = 1'b1
    } pws_state_e;

    typedef struct packed {
        logic blank_q;
        logic lat_q;
    } pws_edge_t;

endpackage

// File: rtl/pws_edge_watch.sv
module pws_edge_watch
    import pws_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blank,
    input  logic lat_gs,
    input  logic tmg_rst_en,
    output logic start
);
    pws_edge_t st_d, st_q;
    logic      blank_fall;
    logic      lat_rise;

    always_comb begin
        st_d         = st_q;
        st_d.blank_q = blank;
        st_d.lat_q   = lat_gs;
        blank_fall   = st_q.blank_q & ~blank;
        lat_rise     = ~st_q.lat_q & lat_gs;
        // blank dominates: a strobe under blank never starts a period
        start        = ~blank & (blank_fall | (lat_rise & tmg_rst_en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.blank_q <= 1'b0;
            st_q.lat_q   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pws_period_ctrl.sv
module pws_period_ctrl
    import pws_pkg::*;
#(
    parameter int GS_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blank,
    input  logic            repeat_en,
    input  logic            start,
    output logic [GS_W:0]   cnt,
    output logic            running,
    output logic            period_end
);
    localparam int CNT_W = GS_W + 1;
    localparam logic [CNT_W-1:0] LAST = {1'b1, {GS_W{1'b0}}};
    localparam logic [CNT_W-1:0] ONE  = {{GS_W{1'b0}}, 1'b1};

    typedef struct packed {
        pws_state_e       st;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  at_last;

    always_comb begin
        c_d     = c_q;
        at_last = (c_q.st == PWS_RUN) && (c_q.cnt == LAST);
        if (blank) begin
            c_d.st  = PWS_IDLE;
            c_d.cnt = '0;
        end else if (start) begin
            c_d.st  = PWS_RUN;
            c_d.cnt = ONE;
        end else if (c_q.st == PWS_RUN) begin
            if (at_last) begin
                if (repeat_en) begin
                    c_d.cnt = ONE;
                end else begin
                    c_d.st  = PWS_IDLE;
                    c_d.cnt = '0;
                end
            end else begin
                c_d.cnt = c_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st  <= PWS_IDLE;
            c_q.cnt <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt        = c_q.cnt;
    assign running    = (c_q.st == PWS_RUN);
    assign period_end = at_last & ~blank;
endmodule

// File: rtl/pws_chan_cmp.sv
module pws_chan_cmp #(
    parameter int GS_W = 12
) (
    input  logic [GS_W:0]   cnt,
    input  logic            running,
    input  logic            blank,
    input  logic [GS_W-1:0] gs,
    output logic            on
);
    logic in_window;
    logic nonzero;

    always_comb begin
        nonzero   = |gs;
        in_window = (cnt <= {1'b0, gs});
        on        = running & ~blank & nonzero & in_window;
    end
endmodule

// File: rtl/pwm_period_seq.sv
module pwm_period_seq #(
    parameter int NUM_CH = 16,
    parameter int GS_W   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   blank,
    input  logic                   repeat_en,
    input  logic                   tmg_rst_en,
    input  logic                   lat_gs,
    input  logic [NUM_CH*GS_W-1:0] gs_data,
    output logic [NUM_CH-1:0]      ch_on,
    output logic                   period_end
);
    logic          start_w;
    logic [GS_W:0] cnt_w;
    logic          run_w;

    pws_edge_watch u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .blank      (blank),
        .lat_gs     (lat_gs),
        .tmg_rst_en (tmg_rst_en),
        .start      (start_w)
    );

    pws_period_ctrl #(.GS_W(GS_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .blank      (blank),
        .repeat_en  (repeat_en),
        .start      (start_w),
        .cnt        (cnt_w),
        .running    (run_w),
        .period_end (period_end)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pws_chan_cmp #(.GS_W(GS_W)) u_cmp (
            .cnt     (cnt_w),
            .running (run_w),
            .blank   (blank),
            .gs      (gs_data[n*GS_W +: GS_W]),
            .on      (ch_on[n])
        );
    end
endmodule

// File: rtl/pwm_period_seq_chk.sv
module pwm_period_seq_chk #(
    parameter int NUM_CH = 16,
    parameter int GS_W   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              blank,
    input logic              repeat_en,
    input logic [NUM_CH-1:0] ch_on,
    input logic              period_end,
    input logic              start,
    input logic [GS_W:0]     cnt,
    input logic              running
);
    localparam logic [GS_W:0] LAST = {1'b1, {GS_W{1'b0}}};
    localparam logic [GS_W:0] ONE  = {{GS_W{1'b0}}, 1'b1};

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        running && !blank && !start && cnt != LAST |=> cnt == $past(cnt) + ONE);

    p_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cnt != '0);

    p_end_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> !period_end);

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        period_end && repeat_en && !start |=> running && cnt == ONE);

    p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        period_end && !repeat_en && !start |=> !running && ch_on == '0);

    p_blank_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> ch_on == '0 && !period_end);

    p_blank_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> !running && cnt == '0);

    p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> running && cnt == ONE);

    p_start_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> !start);
endmodule

bind pwm_period_seq pwm_period_seq_chk #(.NUM_CH(NUM_CH), .GS_W(GS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .blank      (blank),
    .repeat_en  (repeat_en),
    .ch_on      (ch_on),
    .period_end (period_end),
    .start      (start_w),
    .cnt        (cnt_w),
    .running    (run_w)
);

// File: tb/pwm_period_seq_bench.sv
module pwm_period_seq_bench;
    localparam int NUM_CH = 4;
    localparam int GS_W   = 4;
    localparam int P      = 1 << GS_W;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   blank = 1'b0;
    logic                   repeat_en = 1'b0;
    logic                   tmg_rst_en = 1'b0;
    logic                   lat_gs = 1'b0;
    logic [NUM_CH*GS_W-1:0] gs_data;
    logic [NUM_CH-1:0]      ch_on;
    logic                   period_end;
    logic [GS_W-1:0]        gs_arr [NUM_CH];

    int tests  = 0;
    int failed = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int n = 0; n < NUM_CH; n++) gs_data[n*GS_W +: GS_W] = gs_arr[n];
    end

    pwm_period_seq #(.NUM_CH(NUM_CH), .GS_W(GS_W)) u_pwm_period_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .blank      (blank),
        .repeat_en  (repeat_en),
        .tmg_rst_en (tmg_rst_en),
        .lat_gs     (lat_gs),
        .gs_data    (gs_data),
        .ch_on      (ch_on),
        .period_end (period_end)
    );

    function automatic logic [NUM_CH-1:0] exp_mask(int c);
        logic [NUM_CH-1:0] m = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            int v = int'(gs_arr[n]);
            m[n] = (c != 0) && (v != 0) && (c <= v);
        end
        return m;
    endfunction

    task automatic load_gs(int p);
        for (int n = 0; n < NUM_CH; n++) gs_arr[n] = GS_W'((p * NUM_CH + n) % P);
    endtask

    // c = expected count, 0 = idle
    task automatic check_now(int c, string req);
        logic [NUM_CH-1:0] em = exp_mask(c);
        logic              ep = (c == P);
        tests++;
        if (ch_on !== em || period_end !== ep) begin
            failed++;
            $display("FAIL %s count=%0d: ch_on=%b end=%b, expected ch_on=%b end=%b",
                     req, c, ch_on, period_end, em, ep);
        end
    endtask

    task automatic step_expect(int c, string req);
        @(negedge clk);
        check_now(c, req);
    endtask

    initial begin
        load_gs(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) step_expect(0, "R10");

        // strobe without timing-reset enable: no effect
        lat_gs = 1'b1;
        step_expect(0, "R9");
        lat_gs = 1'b0;
        for (int i = 0; i < 2; i++) step_expect(0, "R9");

        // sweep of all grayscale values over four repeating periods
        repeat_en = 1'b1;
        blank = 1'b1;
        step_expect(0, "R7");
        blank = 1'b0;
        for (int p = 0; p < 4; p++) begin
            for (int c = 1; c <= P; c++) begin
                step_expect(c, (c == P) ? "R4 R5" : "R1 R2 R3 R8");
                if (c == P) begin
                    if (p < 3) load_gs(p + 1);
                    else repeat_en = 1'b0;
                end
            end
        end
        for (int i = 0; i < P + 4; i++) step_expect(0, "R6");

        // timing-reset strobe start and mid-period restart
        load_gs(1);
        gs_arr[0] = GS_W'(P - 1);
        tmg_rst_en = 1'b1;
        lat_gs = 1'b1;
        step_expect(1, "R9");
        lat_gs = 1'b0;
        for (int c = 2; c <= 7; c++) step_expect(c, "R1 R9");
        lat_gs = 1'b1;
        step_expect(1, "R9");
        lat_gs = 1'b0;
        for (int c = 2; c <= 5; c++) step_expect(c, "R2 R9");

        // blank mid-period: dark in the same cycle
        blank = 1'b1;
        #1 check_now(0, "R7");
        step_expect(0, "R7");
        lat_gs = 1'b1;
        step_expect(0, "R11");
        lat_gs = 1'b0;
        for (int i = 0; i < 3; i++) step_expect(0, "R11");

        // blank release starts a one-shot period
        blank = 1'b0;
        for (int c = 1; c <= P; c++) step_expect(c, (c == P) ? "R4 R8" : "R3 R8");
        for (int i = 0; i < 4; i++) step_expect(0, "R6");

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            failed++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end
endmodule